// File: doc/BRIEF.md
# Aging-Counter Victim Selector

This block picks a replacement victim among a fixed set of memory frames by approximating least-recently-used order. Every frame has a one-bit "touched" flag and a small age counter. A reference to a frame sets its touched flag. A tick generator inside the block fires at a fixed interval. On each tick, every frame is updated at once: a touched frame has its age cleared, and an untouched frame has its age raised by one. The raise stops at the counter's largest value. All touched flags are then cleared.

The age therefore counts the sampling intervals that have passed since the frame was last used. When the surrounding logic raises a fault request, the block copies all ages and walks the frames one per cycle. It returns the index of the oldest frame and marks the end of the walk with a one-cycle done pulse. If several frames share the largest age, the lowest index wins. The number of frames, the counter width and the tick interval are parameters.

Top module: `aging_lru_approx`

## Requirements
- R1: After reset all ages and touched flags are zero, `tick_o`, `search_busy_o` and `victim_done_o` are low, and a first search returns frame 0.
- R2: `tick_o` is a one-cycle pulse, high in the cycle after TICK_PERIOD-1 clock edges have passed since reset, and again every TICK_PERIOD cycles after that.
- R3: At a tick edge, a frame that was referenced since the previous tick gets age 0.
- R4: At a tick edge, a frame that was not referenced since the previous tick gets its age raised by one, and the age holds at 2^CNT_W-1 rather than wrapping.
- R5: The touched flags are cleared at each tick, so a reference counts for one interval only.
- R6: A reference sampled on the same edge as a tick does not affect that tick's update. It sets the frame's touched flag for the next interval.
- R7: A fault request sampled while the search is idle raises `search_busy_o` for exactly NUM_FRAMES cycles. `victim_done_o` is then high for one cycle, in the first cycle after busy falls.
- R8: While `victim_done_o` is high, `victim_frame_o` holds the index of the largest age among the values at the request edge. A tie goes to the lowest index.
- R9: A fault request sampled while a search is running is ignored. It neither restarts nor extends the search, and it adds no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid_i | input | 1 | A reference is present this cycle |
| ref_frame_i | input | $clog2(NUM_FRAMES) | Index of the frame referenced |
| fault_req_i | input | 1 | Request to select a victim |
| tick_o | output | 1 | Sampling tick, one cycle high per interval |
| search_busy_o | output | 1 | Victim walk in progress |
| victim_done_o | output | 1 | One-cycle pulse, victim index valid |
| victim_frame_o | output | $clog2(NUM_FRAMES) | Selected victim frame index |

## Verification
The assertions rely on TICK_PERIOD being greater than one, so that two ticks never fall on neighbouring edges. They also rely on the fault request being an ordinary level, which may be held high across a running walk. The stimulus holds the request high through a whole walk on purpose, and it places references on the tick edge itself. Request times drift across the tick interval, so some walks begin on the tick edge. The model takes its snapshot from the pre-edge ages, just as the block does.

// File: rtl/aging_lru_pkg.sv
package aging_lru_pkg;
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_e;
endpackage

// File: rtl/aging_tick_gen.sv
module aging_tick_gen #(
    parameter int TICK_PERIOD = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_reg_t;

    tick_reg_t r_d, r_q;

    assign tick_o = (r_q.cnt == LAST);

    always_comb begin
        r_d = r_q;
        if (r_q.cnt == LAST) r_d.cnt = '0;
        else                 r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/aging_frame_slot.sv
module aging_frame_slot #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             hit_i,
    output logic [CNT_W-1:0] age_o
);
    localparam logic [CNT_W-1:0] AGE_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             used;
        logic [CNT_W-1:0] age;
    } slot_reg_t;

    slot_reg_t r_d, r_q;

    assign age_o = r_q.age;

    always_comb begin
        r_d = r_q;
        if (tick_i) begin
            if (r_q.used)              r_d.age = '0;
            else if (r_q.age != AGE_MAX) r_d.age = r_q.age + 1'b1;
            // a hit on the tick edge belongs to the next interval
            r_d.used = hit_i;
        end else if (hit_i) begin
            r_d.used = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/aging_victim_search.sv
module aging_victim_search
    import aging_lru_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int CNT_W      = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start_i,
    input  logic [NUM_FRAMES-1:0][CNT_W-1:0]     ages_i,
    output logic                                 busy_o,
    output logic                                 done_o,
    output logic [$clog2(NUM_FRAMES)-1:0]        victim_o
);
    localparam int IDX_W = $clog2(NUM_FRAMES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

    typedef struct packed {
        walk_state_e                         state;
        logic [IDX_W-1:0]                    idx;
        logic [IDX_W-1:0]                    best_idx;
        logic [CNT_W-1:0]                    best_val;
        logic [NUM_FRAMES-1:0][CNT_W-1:0]    snap;
        logic                                done;
        logic [IDX_W-1:0]                    victim;
    } walk_reg_t;

    walk_reg_t r_d, r_q;
    logic [CNT_W-1:0] cur_val;

    assign cur_val  = r_q.snap[r_q.idx];
    assign busy_o   = (r_q.state == WALK_RUN);
    assign done_o   = r_q.done;
    assign victim_o = r_q.victim;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            WALK_IDLE: begin
                if (start_i) begin
                    r_d.state    = WALK_RUN;
                    r_d.snap     = ages_i;
                    r_d.idx      = '0;
                    r_d.best_idx = '0;
                    r_d.best_val = '0;
                end
            end
            default: begin
                // strictly greater: earlier index keeps a tie
                if (cur_val > r_q.best_val) begin
                    r_d.best_val = cur_val;
                    r_d.best_idx = r_q.idx;
                end
                if (r_q.idx == LAST_IDX) begin
                    r_d.state  = WALK_IDLE;
                    r_d.done   = 1'b1;
                    r_d.victim = (cur_val > r_q.best_val) ? r_q.idx : r_q.best_idx;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/aging_lru_approx.sv
module aging_lru_approx #(
    parameter int NUM_FRAMES  = 8,
    parameter int CNT_W       = 3,
    parameter int TICK_PERIOD = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ref_valid_i,
    input  logic [$clog2(NUM_FRAMES)-1:0] ref_frame_i,
    input  logic                          fault_req_i,
    output logic                          tick_o,
    output logic                          search_busy_o,
    output logic                          victim_done_o,
    output logic [$clog2(NUM_FRAMES)-1:0] victim_frame_o
);
    localparam int IDX_W = $clog2(NUM_FRAMES);

    logic                             tick;
    logic [NUM_FRAMES-1:0][CNT_W-1:0] ages;

    aging_tick_gen #(.TICK_PERIOD(TICK_PERIOD)) tick_gen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_slot
        logic hit;
        assign hit = ref_valid_i && (ref_frame_i == IDX_W'(g));
        aging_frame_slot #(.CNT_W(CNT_W)) slot_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick),
            .hit_i  (hit),
            .age_o  (ages[g])
        );
    end

    aging_victim_search #(.NUM_FRAMES(NUM_FRAMES), .CNT_W(CNT_W)) search_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (fault_req_i),
        .ages_i   (ages),
        .busy_o   (search_busy_o),
        .done_o   (victim_done_o),
        .victim_o (victim_frame_o)
    );

    assign tick_o = tick;
endmodule

// File: rtl/aging_lru_checker.sv
module aging_lru_checker #(
    parameter int NUM_FRAMES  = 8,
    parameter int TICK_PERIOD = 16
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic busy,
    input logic done,
    input logic fault
);
    logic [31:0] gap_q;
    logic [31:0] lat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
            lat_q <= '0;
        end else begin
            gap_q <= tick ? '0 : gap_q + 1;
            lat_q <= busy ? lat_q + 1 : '0;
        end
    end

    assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q == 32'(TICK_PERIOD - 1)));
    assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == 32'(NUM_FRAMES)));
    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    assert_start_needs_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(fault));
endmodule

bind aging_lru_approx aging_lru_checker #(
    .NUM_FRAMES  (NUM_FRAMES),
    .TICK_PERIOD (TICK_PERIOD)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_o),
    .busy  (search_busy_o),
    .done  (victim_done_o),
    .fault (fault_req_i)
);

// File: tb/aging_lru_approx_tb.sv
module aging_lru_approx_tb_top;
    localparam int N    = 8;
    localparam int CW   = 3;
    localparam int P    = 16;
    localparam int IW   = $clog2(N);
    localparam int AMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_valid = 1'b0;
    logic [IW-1:0] ref_frame = '0;
    logic          fault_req = 1'b0;
    logic          tick_o, busy_o, done_o;
    logic [IW-1:0] victim_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int m_age [N];
    bit m_used [N];
    bit m_busy = 0;
    bit m_done = 0;
    int m_left = 0;
    int m_vict = 0;
    int done_seen = 0;
    string scen = "R1 reset";
    bit finished = 0;

    always #5 clk = ~clk;

    aging_lru_approx #(.NUM_FRAMES(N), .CNT_W(CW), .TICK_PERIOD(P)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .ref_valid_i    (ref_valid),
        .ref_frame_i    (ref_frame),
        .fault_req_i    (fault_req),
        .tick_o         (tick_o),
        .search_busy_o  (busy_o),
        .victim_done_o  (done_o),
        .victim_frame_o (victim_o)
    );

    function automatic int oldest();
        int best = 0;
        for (int f = 1; f < N; f++) if (m_age[f] > m_age[best]) best = f;
        return best;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s [%s] actual=%0d expected=%0d at cycle %0d", req, scen, act, exp, cyc);
        end
    endtask

    // reference model driven by the requirements (R3 R4 R5 R6 R7 R8 R9)
    always @(posedge clk) begin
        if (!rst_n) begin
            cyc <= 0;
            for (int f = 0; f < N; f++) begin m_age[f] <= 0; m_used[f] <= 0; end
            m_busy <= 0; m_left <= 0; m_done <= 0;
        end else begin
            cyc <= cyc + 1;
            if (cyc % P == P - 1) begin
                for (int f = 0; f < N; f++) begin
                    m_age[f]  <= m_used[f] ? 0 : ((m_age[f] == AMAX) ? AMAX : m_age[f] + 1);
                    m_used[f] <= ref_valid && (int'(ref_frame) == f);
                end
            end else if (ref_valid) begin
                m_used[ref_frame] <= 1;
            end
            m_done <= 0;
            if (!m_busy) begin
                if (fault_req) begin m_busy <= 1; m_left <= N; m_vict <= oldest(); end
            end else begin
                m_left <= m_left - 1;
                if (m_left == 1) begin m_busy <= 0; m_done <= 1; end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            check(!tick_o && !busy_o && !done_o, "R1", {tick_o, busy_o, done_o}, 0);
        end else if (!finished) begin
            check(tick_o == (cyc % P == P - 1), "R2", tick_o, int'(cyc % P == P - 1));
            check(busy_o == m_busy, "R7", busy_o, m_busy);
            check(done_o == m_done, "R7", done_o, m_done);
            if (done_o) done_seen++;
            if (done_o && m_done) check(int'(victim_o) == m_vict, "R8", victim_o, m_vict);
        end
    end

    task automatic drive(input bit v, input int fr, input bit fq);
        @(negedge clk);
        ref_valid = v; ref_frame = IW'(fr); fault_req = fq;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0);
    endtask

    task automatic wait_tick_cycle();
        // returns at a negedge where the coming edge is a tick edge
        @(negedge clk);
        while (cyc % P != P - 1) @(negedge clk);
    endtask

    task automatic fault_and_wait();
        drive(0, 0, 1);
        idle(N + 2);
    endtask

    initial begin
        #100000000;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: first search after reset sees all-zero ages, victim 0
        fault_and_wait();

        // R4 saturation with R8 tie: frames 0 and 1 kept busy for many intervals
        scen = "R4 saturation";
        for (int t = 0; t < 10 * P; t++) drive(1, t % 2, 0);
        fault_and_wait();
        check(m_age[2] == AMAX, "R4", m_age[2], AMAX);

        // R3: touch frame 2 only during one interval, then walk
        scen = "R3 used clears";
        wait_tick_cycle();
        drive(0, 0, 0);
        drive(1, 2, 0);
        idle(P);
        fault_and_wait();

        // R5: no references in the next interval, frame 2 ages again
        scen = "R5 flag cleared";
        idle(2 * P);
        fault_and_wait();

        // R6: reference landing exactly on the tick edge
        scen = "R6 tick edge ref";
        wait_tick_cycle();
        ref_valid = 1'b1; ref_frame = IW'(5);
        drive(0, 0, 0);
        fault_and_wait();
        idle(P);
        fault_and_wait();

        // R9: request held high throughout a walk gives one done pulse
        scen = "R9 held request";
        idle(2);
        done_seen = 0;
        for (int i = 0; i < N; i++) drive(0, 0, 1);
        idle(2 * N);
        check(done_seen == 1, "R9", done_seen, 1);

        // sweep: per-interval reference masks, request offset drifting
        scen = "R8 sweep";
        for (int r = 0; r < 60; r++) begin
            int mask = (r * 37 + 11) & 8'hFF;
            int at = (r * 5) % P;
            for (int k = 0; k < P; k++) begin
                drive(mask[k % N], k % N, 0);
                if (k == at) begin
                    drive(0, 0, 1);
                    drive(0, 0, 0);
                end
            end
            idle(N + 2);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule